// File: doc/BRIEF.md
# H-Bridge Drive Control Core with Fault Latch

This block is the digital core of a full-bridge motor or solenoid driver. Two direction inputs choose one of four bridge states: forward, reverse, brake through both low sides, or brake through both high sides. A coding strap selects one of two operating modes. With the strap low, two disable inputs can turn the bridge off. One disable input is active high and the other is active low. With the strap high, the disable inputs are ignored. The block produces four gate commands, one for each switch of the two half-bridges. A half-bridge with both commands low is at high impedance. The block also drives an active-low status flag.

Supply, temperature and overcurrent monitors report through single-bit comparator flags. Undervoltage turns the bridge off only while it lasts. Overcurrent and overtemperature are stored. A stored fault is released only by a chosen edge on the pins that the strap selects, and only when no fault flag is present in that cycle. All pin inputs pass through two synchroniser flops. A driven state takes effect only after the new request has been stable for a parameterised number of clock cycles. One count applies to drive states and a separate count applies to the disabled state.

Top module: `hbridge_ctrl`

## Requirements
- R1: With no fault and no disable, the direction inputs decode as follows. {dir_a,dir_b}=10 gives forward (a_hi, b_lo). 01 gives reverse (a_lo, b_hi). 00 gives low brake (a_lo, b_lo). 11 gives high brake (a_hi, b_hi).
- R2: With mode_sel low, inh_hi high or inh_lo_n low selects the disabled state. All four gate commands are low and stat_n is low.
- R3: With mode_sel high, inh_hi and inh_lo_n have no effect on the gate commands or on stat_n.
- R4: While uv_det is high, all gate commands are low from the next clock edge and stat_n is low. After uv_det falls, stat_n returns high at once, and drive resumes from the inputs with no other action.
- R5: oc_hi_det, oc_lo_det or ot_det high turns all gate commands off at the next edge, whatever the inputs are. The fault is stored: outputs stay off and stat_n stays low after the flag drops.
- R6: With mode_sel low, a stored fault clears on a falling edge of inh_hi or a rising edge of inh_lo_n. These edges are detected after synchronisation.
- R7: With mode_sel high, a stored fault clears on a falling edge of dir_a or a rising edge of dir_b. Edges on inh_hi and inh_lo_n do not clear it.
- R8: A clearing edge has no effect if any fault flag is high in the same cycle. In that case the fault stays stored, so an overtemperature fault cannot be released while the die is still hot.
- R9: A new requested state reaches the gate commands on the (D+3)-th rising edge after the inputs change. D is DIS_DLY when the new state is the disabled state and DRV_DLY for the four drive states.
- R10: A request that returns to its previous value before its delay expires produces no change at the gate commands.
- R11: The high-side and low-side commands of one half-bridge are never high together.
- R12: After reset, all gate commands are low and stat_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Direction input for half-bridge A |
| dir_b | input | 1 | Direction input for half-bridge B |
| inh_hi | input | 1 | Disable, active high; clears faults on falling edge when mode_sel is low |
| inh_lo_n | input | 1 | Disable, active low; clears faults on rising edge when mode_sel is low |
| mode_sel | input | 1 | Coding strap: high ignores the disables and moves fault clearing to the direction inputs |
| uv_det | input | 1 | Supply undervoltage comparator flag |
| ot_det | input | 1 | Overtemperature comparator flag |
| oc_hi_det | input | 1 | High-side overcurrent comparator flag |
| oc_lo_det | input | 1 | Low-side overcurrent comparator flag |
| a_hi | output | 1 | Half-bridge A high-side gate command |
| a_lo | output | 1 | Half-bridge A low-side gate command |
| b_hi | output | 1 | Half-bridge B high-side gate command |
| b_lo | output | 1 | Half-bridge B low-side gate command |
| stat_n | output | 1 | Status flag, low on stored fault, undervoltage or disable |

## Verification
The hardest case to reach is a clearing edge that lands in the same cycle as a fault flag. The edge only becomes visible two synchroniser stages after the pin moves. The stimulus therefore releases the disable pin and raises an overcurrent pulse timed to match that pipeline depth. Over a separate stretch it also holds the temperature flag high across a full clearing pulse. Glitches shorter than the programmed delay exercise the restart of the delay counter. The reference model follows every cycle, so any early or late transition shows up as a mismatch.

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl #(
  parameter int DRV_DLY = 1875,
  parameter int DIS_DLY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_a,
  input  logic dir_b,
  input  logic inh_hi,
  input  logic inh_lo_n,
  input  logic mode_sel,
  input  logic uv_det,
  input  logic ot_det,
  input  logic oc_hi_det,
  input  logic oc_lo_det,
  output logic a_hi,
  output logic a_lo,
  output logic b_hi,
  output logic b_lo,
  output logic stat_n
);
  localparam int MAXD = (DRV_DLY > DIS_DLY) ? DRV_DLY : DIS_DLY;
  localparam int CW   = (MAXD < 2) ? 1 : $clog2(MAXD + 1);
  localparam logic [CW-1:0] DRV_LD = CW'(DRV_DLY - 1);
  localparam logic [CW-1:0] DIS_LD = CW'(DIS_DLY - 1);
  localparam int IA = 0, IB = 1, IH = 2, IL = 3, IM = 4;

  typedef enum logic [2:0] {
    MD_OFF, MD_DIS, MD_FWD, MD_REV, MD_BLO, MD_BHI
  } mode_t;

  logic [4:0] sy1, sy2, sy3;
  logic       flt_q, uv_q;
  mode_t      cur, pend, tgt;
  logic [CW-1:0] cnt;
  logic       fault_now, urgent, clr_edge, disabled;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= {mode_sel, inh_lo_n, inh_hi, dir_b, dir_a};
      sy2 <= sy1;
      sy3 <= sy2;
    end

  assign fault_now = oc_hi_det | oc_lo_det | ot_det;
  assign urgent    = flt_q | fault_now | uv_det;
  assign clr_edge  = sy2[IM] ? ((sy3[IA] & ~sy2[IA]) | (~sy3[IB] & sy2[IB]))
                             : ((sy3[IH] & ~sy2[IH]) | (~sy3[IL] & sy2[IL]));
  assign disabled  = ~sy2[IM] & (sy2[IH] | ~sy2[IL]);

  always_comb begin
    unique case ({sy2[IA], sy2[IB]})
      2'b10:   tgt = MD_FWD;
      2'b01:   tgt = MD_REV;
      2'b00:   tgt = MD_BLO;
      default: tgt = MD_BHI;
    endcase
    if (disabled) tgt = MD_DIS;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_q <= 1'b0;
      uv_q  <= 1'b0;
    end else begin
      uv_q <= uv_det;
      if (fault_now)     flt_q <= 1'b1;
      else if (clr_edge) flt_q <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur  <= MD_OFF;
      pend <= MD_OFF;
      cnt  <= '0;
    end else if (urgent) begin
      cur  <= MD_OFF;
      pend <= MD_OFF;
      cnt  <= '0;
    end else if (tgt != pend) begin
      pend <= tgt;
      cnt  <= (tgt == MD_DIS) ? DIS_LD : DRV_LD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      cur <= pend;
    end

  assign a_hi   = (cur == MD_FWD) | (cur == MD_BHI);
  assign a_lo   = (cur == MD_REV) | (cur == MD_BLO);
  assign b_hi   = (cur == MD_REV) | (cur == MD_BHI);
  assign b_lo   = (cur == MD_FWD) | (cur == MD_BLO);
  assign stat_n = ~(flt_q | uv_q | (cur == MD_DIS));
endmodule

module hbridge_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic uv_det,
  input logic ot_det,
  input logic oc_hi_det,
  input logic oc_lo_det,
  input logic a_hi,
  input logic a_lo,
  input logic b_hi,
  input logic b_lo,
  input logic stat_n
);
  logic idle;
  assign idle = ~(a_hi | a_lo | b_hi | b_lo);

  p_leg_a_r11: assert property (@(posedge clk) disable iff (!rst_n) !(a_hi && a_lo));
  p_leg_b_r11: assert property (@(posedge clk) disable iff (!rst_n) !(b_hi && b_lo));
  p_fault_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_hi_det || oc_lo_det || ot_det) |=> (idle && !stat_n));
  p_uv_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uv_det |=> (idle && !stat_n));
  p_flag_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_n |-> idle);
  p_hot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_det && $past(ot_det)) |=> !stat_n);
endmodule

bind hbridge_ctrl hbridge_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uv_det(uv_det), .ot_det(ot_det),
  .oc_hi_det(oc_hi_det), .oc_lo_det(oc_lo_det), .a_hi(a_hi), .a_lo(a_lo),
  .b_hi(b_hi), .b_lo(b_lo), .stat_n(stat_n)
);

// File: tb/sim_hbridge_ctrl.sv
module sim_hbridge_ctrl;
  localparam int DRV = 12;
  localparam int DIS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_a = 0, dir_b = 0, inh_hi = 0, inh_lo_n = 1, mode_sel = 0;
  logic uv_det = 0, ot_det = 0, oc_hi_det = 0, oc_lo_det = 0;
  logic a_hi, a_lo, b_hi, b_lo, stat_n;

  always #4 clk = ~clk;

  hbridge_ctrl #(.DRV_DLY(DRV), .DIS_DLY(DIS)) u0 (
    .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b), .inh_hi(inh_hi),
    .inh_lo_n(inh_lo_n), .mode_sel(mode_sel), .uv_det(uv_det), .ot_det(ot_det),
    .oc_hi_det(oc_hi_det), .oc_lo_det(oc_lo_det), .a_hi(a_hi), .a_lo(a_lo),
    .b_hi(b_hi), .b_lo(b_lo), .stat_n(stat_n)
  );

  // model modes: 0 off, 1 disabled, 2 fwd, 3 rev, 4 low brake, 5 high brake
  int n_chk = 0, n_bad = 0;
  string tag = "R12";
  bit pipe[$][5];
  bit prv[5];
  int m_cur = 0, m_last = 0, m_age = 0;
  bit m_flt = 0, m_uv = 0;

  function automatic logic [3:0] gates(int md);
    case (md)
      2: return 4'b1001;
      3: return 4'b0110;
      4: return 4'b0101;
      5: return 4'b1010;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic int want(bit s[5]);
    if (!s[4] && (s[2] || !s[3])) return 1;
    if (s[0] && !s[1]) return 2;
    if (!s[0] && s[1]) return 3;
    if (!s[0]) return 4;
    return 5;
  endfunction

  task automatic model_reset();
    bit z[5];
    foreach (z[i]) z[i] = 0;
    pipe = {};
    pipe.push_back(z);
    pipe.push_back(z);
    prv = z;
    m_cur = 0; m_last = 0; m_age = 0; m_flt = 0; m_uv = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit s[5];
      bit nw[5];
      bit clr, hit;
      int t, d;
      s = pipe[1];
      t = want(s);
      clr = s[4] ? ((prv[0] && !s[0]) || (!prv[1] && s[1]))
                 : ((prv[2] && !s[2]) || (!prv[3] && s[3]));
      hit = oc_hi_det || oc_lo_det || ot_det;
      if (m_flt || hit || uv_det) begin
        m_cur = 0; m_last = 0; m_age = 0;
      end else begin
        d = (t == 1) ? DIS : DRV;
        if (t != m_last) begin m_last = t; m_age = 0; end
        else if (m_age < d) m_age++;
        if (m_age >= d) m_cur = m_last;
      end
      if (hit) m_flt = 1;
      else if (clr) m_flt = 0;
      m_uv = uv_det;
      prv = s;
      nw[0] = dir_a; nw[1] = dir_b; nw[2] = inh_hi; nw[3] = inh_lo_n; nw[4] = mode_sel;
      pipe.pop_back();
      pipe.push_front(nw);
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic [3:0] g, e;
    logic ef;
    g = {a_hi, a_lo, b_hi, b_lo};
    e = gates(m_cur);
    ef = !(m_flt || m_uv || m_cur == 1);
    n_chk++;
    if (g !== e) begin
      n_bad++;
      $display("FAIL %s gates got %b expected %b at %0t", tag, g, e, $time);
    end
    n_chk++;
    if (stat_n !== ef) begin
      n_bad++;
      $display("FAIL %s stat_n got %b expected %b at %0t", tag, stat_n, ef, $time);
    end
    n_chk++;
    if ((a_hi && a_lo) || (b_hi && b_lo)) begin
      n_bad++;
      $display("FAIL R11 leg overlap got %b expected no pair at %0t", g, $time);
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_oc(bit hs);
    if (hs) oc_hi_det = 1; else oc_lo_det = 1;
    wait_n(1);
    oc_hi_det = 0; oc_lo_det = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    wait_n(3);
    n_chk++;
    if ({a_hi, a_lo, b_hi, b_lo, stat_n} !== 5'b00001) begin
      n_bad++;
      $display("FAIL R12 reset got %b expected 00001", {a_hi, a_lo, b_hi, b_lo, stat_n});
    end
    rst_n = 1;
    wait_n(20);
    tag = "R1"; dir_a = 1; dir_b = 0; wait_n(30);
    dir_a = 0; dir_b = 1; wait_n(30);
    dir_a = 0; dir_b = 0; wait_n(30);
    tag = "R9"; dir_a = 1; dir_b = 1; wait_n(30);
    tag = "R10"; dir_b = 0; wait_n(4); dir_b = 1; wait_n(30);
    tag = "R2"; inh_hi = 1; wait_n(30); inh_hi = 0; wait_n(30);
    inh_lo_n = 0; wait_n(30); inh_lo_n = 1; wait_n(30);
    tag = "R3"; mode_sel = 1; wait_n(10); inh_hi = 1; wait_n(30);
    inh_lo_n = 0; wait_n(30); inh_hi = 0; inh_lo_n = 1; wait_n(10);
    mode_sel = 0; wait_n(30);
    tag = "R4"; uv_det = 1; wait_n(10); uv_det = 0; wait_n(30);
    tag = "R5"; pulse_oc(1); wait_n(30);
    tag = "R6"; inh_hi = 1; wait_n(10); inh_hi = 0; wait_n(30);
    tag = "R5"; pulse_oc(0); wait_n(20);
    tag = "R6"; inh_lo_n = 0; wait_n(10); inh_lo_n = 1; wait_n(30);
    tag = "R8"; ot_det = 1; wait_n(5); inh_hi = 1; wait_n(10); inh_hi = 0; wait_n(10);
    ot_det = 0; wait_n(20); inh_hi = 1; wait_n(10); inh_hi = 0; wait_n(30);
    pulse_oc(1); wait_n(10); inh_hi = 1; wait_n(10);
    inh_hi = 0; wait_n(2); pulse_oc(0); wait_n(30);
    inh_hi = 1; wait_n(10); inh_hi = 0; wait_n(30);
    tag = "R7"; mode_sel = 1; wait_n(10); pulse_oc(1); wait_n(10);
    inh_hi = 1; wait_n(10); inh_hi = 0; wait_n(20);
    dir_a = 0; wait_n(30);
    pulse_oc(0); wait_n(10); inh_lo_n = 0; wait_n(10); inh_lo_n = 1; wait_n(20);
    dir_b = 0; wait_n(10); dir_b = 1; wait_n(30);
    tag = "R1"; dir_a = 1; dir_b = 0; wait_n(30);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule